// File: doc/BRIEF.md
# Sized Load-Store Unit with Exclusive Reservation

This unit sits between a processor pipeline and a byte-addressed data memory that is 64 bits wide. For each request it adds a sign-extended immediate to a base register to form the effective address. For a store it drives the byte-lane enables and shifts the write data into those lanes. For a load it takes the returned doubleword, picks out the bytes that were asked for and extends them to 64 bits. The memory is synchronous, so load data comes back one cycle after the request.

The unit also holds one exclusive reservation. A load-exclusive reads a doubleword at the bare base address and arms the reservation. A later store-exclusive to the same doubleword writes its data and returns status 0. A store-exclusive that finds no matching reservation writes nothing and returns status 1. In both cases the status goes to a second destination register. Any access that is not naturally aligned for its size is refused. The unit flags it on an error output and makes no memory access.

Top module: `lsu_core`

## Requirements
- R1: `req_op` is encoded as 0 load, 1 store, 2 load-exclusive, 3 store-exclusive. `req_size` is encoded as 0 byte, 1 halfword, 2 word, 3 doubleword. For ordinary loads and stores the effective address (EA) is `req_base` plus `req_offset` sign-extended. `mem_addr` is the EA with its three low bits cleared.
- R2: Both exclusive kinds ignore `req_offset` and `req_size`. They use `req_base` as the EA and always access a full doubleword.
- R3: A store enables 2^size consecutive byte lanes, starting at lane EA[2:0] (lane i is `mem_be[i]` and data bits 8i+7..8i, in little-endian order). The store data, least significant byte first, lands in those lanes.
- R4: A load asserts `mem_rd_en` in its request cycle and `ld_valid` exactly one cycle later. Byte and halfword results are zero-extended.
- R5: A word load sign-extends bit 31 of the selected word into bits 63..32.
- R6: A doubleword load, including a load-exclusive, returns all 64 bits unchanged.
- R7: An access whose EA is not a multiple of its size raises `align_err` in the request cycle. It then produces no read, no write, no `ld_valid` and no `stx_valid`, and it leaves the reservation unchanged.
- R8: An aligned load-exclusive sets the reservation to its doubleword address and replaces any earlier reservation.
- R9: A store-exclusive whose doubleword matches a valid reservation writes all eight lanes. One cycle later it gives `stx_valid` with `stx_status` = 0.
- R10: A store-exclusive with no matching reservation performs no write. One cycle later it gives `stx_valid` with `stx_status` = 1.
- R11: Every aligned store-exclusive clears the reservation. An ordinary store that touches the reserved doubleword also clears it. Ordinary loads and stores to other doublewords leave it in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Access kind |
| req_size | input | 2 | Access size as log2 of bytes |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | OFF_W | Signed immediate offset |
| req_wdata | input | 64 | Store data, right-justified |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Doubleword-aligned byte address |
| mem_be | output | 8 | Byte-lane write enables |
| mem_wdata | output | 64 | Lane-steered write data |
| mem_rdata | input | 64 | Read data, valid the cycle after `mem_rd_en` |
| align_err | output | 1 | Misaligned request refused |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Extended load result |
| stx_valid | output | 1 | Store-exclusive status valid |
| stx_status | output | 64 | 0 on success, 1 on failure |

## Verification
The assertions assume that the pipeline presents at most one request per cycle. They also assume that every request field is defined whenever `req_valid` is high, and that `mem_rdata` holds the addressed doubleword in the cycle after a read strobe. The bench meets these conditions. It drives each request for exactly one clock, separated by idle cycles, with every field set. Its own memory model answers reads on the following edge. The bench keeps all addresses inside that model's 256-byte window, so no request wraps or goes outside the modelled memory.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int DATA_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LDX   = 2'd2,
    OP_STX   = 2'd3
  } lsu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } lsu_size_e;

  // lanes touched by an access of 2^sz bytes starting at lane
  function automatic logic [LANES-1:0] lane_mask(lsu_size_e sz, logic [LANE_W-1:0] lane);
    logic [LANES-1:0] run;
    run = LANES'((32'd1 << (32'd1 << sz)) - 32'd1);
    return run << lane;
  endfunction

  function automatic logic is_aligned(lsu_size_e sz, logic [LANE_W-1:0] lane);
    logic [LANE_W-1:0] low;
    low = LANE_W'((32'd1 << sz) - 32'd1);
    return (lane & low) == '0;
  endfunction

  function automatic logic [DATA_W-1:0] steer(logic [DATA_W-1:0] d, logic [LANE_W-1:0] lane);
    return d << {lane, 3'b000};
  endfunction

  function automatic logic [DATA_W-1:0] extract(logic [DATA_W-1:0] d, logic [LANE_W-1:0] lane,
                                                lsu_size_e sz);
    logic [DATA_W-1:0] sh;
    sh = d >> {lane, 3'b000};
    case (sz)
      SZ_BYTE: return {{(DATA_W-8){1'b0}}, sh[7:0]};
      SZ_HALF: return {{(DATA_W-16){1'b0}}, sh[15:0]};
      SZ_WORD: return {{(DATA_W-32){sh[31]}}, sh[31:0]};
      default: return sh;
    endcase
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 12
) (
  input  lsu_op_e           op_i,
  input  lsu_size_e         size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] ea_o,
  output lsu_size_e         size_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              aligned_o
);
  logic              excl;
  logic [ADDR_W-1:0] off_ext;

  assign excl    = (op_i == OP_LDX) || (op_i == OP_STX);
  assign off_ext = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign ea_o    = excl ? base_i : base_i + off_ext;
  assign size_o  = excl ? SZ_DBL : size_i;
  assign lane_o  = ea_o[LANE_W-1:0];
  assign aligned_o = is_aligned(size_o, lane_o);
endmodule

// File: rtl/lsu_store_path.sv
module lsu_store_path
  import lsu_pkg::*;
(
  input  logic              en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANE_W-1:0] lane_i,
  input  lsu_size_e         size_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] data_o
);
  assign be_o   = en_i ? lane_mask(size_i, lane_i) : '0;
  assign data_o = steer(wdata_i, lane_i);
endmodule

// File: rtl/lsu_load_ret.sv
module lsu_load_ret
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [LANE_W-1:0] lane_i,
  input  lsu_size_e         size_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [LANE_W-1:0] lane_q;
  lsu_size_e         size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      lane_q  <= '0;
      size_q  <= SZ_BYTE;
    end else begin
      valid_q <= issue_i;
      if (issue_i) begin
        lane_q <= lane_i;
        size_q <= size_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = valid_q ? extract(rdata_i, lane_q, size_q) : '0;

  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> valid_o); // R4
endmodule

// File: rtl/lsu_excl_mon.sv
module lsu_excl_mon #(
  parameter int DW_W = 61
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ldx_i,
  input  logic            stx_i,
  input  logic            st_i,
  input  logic [DW_W-1:0] dw_i,
  output logic            res_valid_o,
  output logic            match_o
);
  logic            res_valid_q;
  logic [DW_W-1:0] res_dw_q;
  logic            plain_hit;

  assign match_o   = res_valid_q && (res_dw_q == dw_i);
  assign plain_hit = st_i && match_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_dw_q    <= '0;
    end else if (ldx_i) begin
      res_valid_q <= 1'b1;
      res_dw_q    <= dw_i;
    end else if (stx_i || plain_hit) begin
      res_valid_q <= 1'b0;
    end
  end

  assign res_valid_o = res_valid_q;

  AST_LDX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ldx_i |=> res_valid_o && (res_dw_q == $past(dw_i))); // R8
  AST_STX_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    stx_i |=> !res_valid_o); // R11
  AST_STORE_HIT_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_i && match_o) |=> !res_valid_o); // R11
  AST_RES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(ldx_i || stx_i || st_i) |=> $stable(res_valid_o)); // R11
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [63:0]       req_wdata,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  output logic              align_err,
  output logic              ld_valid,
  output logic [63:0]       ld_data,
  output logic              stx_valid,
  output logic [63:0]       stx_status
);
  localparam int DW_W = ADDR_W - LANE_W;

  lsu_op_e           op;
  logic [ADDR_W-1:0] ea;
  lsu_size_e         eff_size;
  logic [LANE_W-1:0] lane;
  logic              aligned;

  // named internal events
  logic              acc_ok;
  logic              ev_load;
  logic              ev_store;
  logic              ev_ldx;
  logic              ev_stx;
  logic              res_valid;
  logic              res_match;
  logic              write_go;

  logic              stx_valid_q;
  logic              stx_fail_q;

  assign op = lsu_op_e'(req_op);

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .op_i      (op),
    .size_i    (lsu_size_e'(req_size)),
    .base_i    (req_base),
    .offset_i  (req_offset),
    .ea_o      (ea),
    .size_o    (eff_size),
    .lane_o    (lane),
    .aligned_o (aligned)
  );

  assign align_err = req_valid && !aligned;
  assign acc_ok    = req_valid && aligned;
  assign ev_load   = acc_ok && (op == OP_LOAD);
  assign ev_store  = acc_ok && (op == OP_STORE);
  assign ev_ldx    = acc_ok && (op == OP_LDX);
  assign ev_stx    = acc_ok && (op == OP_STX);

  lsu_excl_mon #(.DW_W(DW_W)) u_excl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ldx_i       (ev_ldx),
    .stx_i       (ev_stx),
    .st_i        (ev_store),
    .dw_i        (ea[ADDR_W-1:LANE_W]),
    .res_valid_o (res_valid),
    .match_o     (res_match)
  );

  assign write_go  = ev_store || (ev_stx && res_match);
  assign mem_wr_en = write_go;
  assign mem_rd_en = ev_load || ev_ldx;
  assign mem_addr  = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  lsu_store_path u_store (
    .en_i    (write_go),
    .wdata_i (req_wdata),
    .lane_i  (lane),
    .size_i  (eff_size),
    .be_o    (mem_be),
    .data_o  (mem_wdata)
  );

  lsu_load_ret u_load (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (mem_rd_en),
    .lane_i  (lane),
    .size_i  (eff_size),
    .rdata_i (mem_rdata),
    .valid_o (ld_valid),
    .data_o  (ld_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stx_valid_q <= 1'b0;
      stx_fail_q  <= 1'b0;
    end else begin
      stx_valid_q <= ev_stx;
      if (ev_stx) stx_fail_q <= !res_match;
    end
  end

  assign stx_valid  = stx_valid_q;
  assign stx_status = {{(DATA_W-1){1'b0}}, stx_fail_q};

  AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> !mem_rd_en && !mem_wr_en); // R7
  AST_STX_WRITE_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && op == OP_STX) |-> res_valid && mem_be == '1); // R9
  AST_STATUS_AFTER_STX: assert property (@(posedge clk) disable iff (!rst_n)
    stx_valid |-> $past(req_valid && op == OP_STX && aligned)); // R10
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_rd_en)); // R4
  AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> mem_be[lane] && mem_be != '0); // R3
endmodule

// File: tb/lsu_core_tb.sv
`timescale 1ns/1ps
module lsu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_base = '0;
  logic [11:0] req_offset = '0;
  logic [63:0] req_wdata = '0;
  logic        mem_rd_en, mem_wr_en, align_err, ld_valid, stx_valid;
  logic [63:0] mem_addr, mem_wdata, ld_data, stx_status;
  logic [7:0]  mem_be;
  logic [63:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;

  logic [63:0] tb_mem  [32];
  logic [63:0] ref_mem [32];
  bit          ref_res_v = 0;
  logic [63:0] ref_res_dw = '0;

  always #2.5 clk = ~clk;

  lsu_core #(.ADDR_W(64), .OFF_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_base(req_base), .req_offset(req_offset),
    .req_wdata(req_wdata), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .align_err(align_err), .ld_valid(ld_valid),
    .ld_data(ld_data), .stx_valid(stx_valid), .stx_status(stx_status)
  );

  // synchronous memory driven only by the design's strobes
  always @(posedge clk) begin
    if (mem_wr_en)
      for (int i = 0; i < 8; i++)
        if (mem_be[i]) tb_mem[mem_addr[7:3]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
    if (mem_rd_en) mem_rdata <= tb_mem[mem_addr[7:3]];
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input int op, input int sz, input logic [63:0] base,
                        input logic [11:0] off, input logic [63:0] wd);
    logic [63:0] ea, exp_ld, exp_wd;
    logic [7:0]  exp_be;
    int          esz, nb, lane, idx;
    bit          excl, ok_al, exp_rd, exp_wr, exp_stx, stx_ok;
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_size = 2'(sz);
    req_base = base; req_offset = off; req_wdata = wd;
    #1;
    excl = (op >= 2);
    ea   = excl ? base : base + {{52{off[11]}}, off};
    esz  = excl ? 3 : sz;
    nb   = 1 << esz;
    lane = int'(ea[2:0]);
    idx  = int'(ea[7:3]);
    ok_al = (lane % nb) == 0;
    stx_ok  = ref_res_v && (ref_res_dw == (ea >> 3));
    exp_rd  = ok_al && (op == 0 || op == 2);
    exp_wr  = ok_al && (op == 1 || (op == 3 && stx_ok));
    exp_stx = ok_al && op == 3;
    chk(align_err == !ok_al, "R7", "align_err", 64'(align_err), 64'(!ok_al));
    chk(mem_rd_en == exp_rd, exp_rd ? "R4" : "R7", "mem_rd_en", 64'(mem_rd_en), 64'(exp_rd));
    chk(mem_wr_en == exp_wr, op == 3 ? (stx_ok ? "R9" : "R10") : "R7", "mem_wr_en",
        64'(mem_wr_en), 64'(exp_wr));
    if (exp_rd || exp_wr)
      chk(mem_addr == {ea[63:3], 3'b000}, excl ? "R2" : "R1", "mem_addr", mem_addr,
          {ea[63:3], 3'b000});
    exp_be = '0; exp_wd = mem_wdata;
    for (int i = 0; i < nb; i++) begin
      exp_be[lane+i] = 1'b1;
      exp_wd[(lane+i)*8 +: 8] = wd[i*8 +: 8];
    end
    if (exp_wr) begin
      chk(mem_be == exp_be, "R3", "mem_be", 64'(mem_be), 64'(exp_be));
      chk(mem_wdata == exp_wd, "R3", "mem_wdata", mem_wdata, exp_wd);
    end
    exp_ld = '0;
    for (int i = 0; i < nb; i++) exp_ld[i*8 +: 8] = ref_mem[idx][(lane+i)*8 +: 8];
    if (esz == 2 && exp_ld[31]) exp_ld[63:32] = '1;
    // reference state update
    if (exp_wr)
      for (int i = 0; i < nb; i++) ref_mem[idx][(lane+i)*8 +: 8] = wd[i*8 +: 8];
    if (ok_al) begin
      if (op == 2) begin ref_res_v = 1; ref_res_dw = ea >> 3; end
      else if (op == 3) ref_res_v = 0;
      else if (op == 1 && ref_res_v && ref_res_dw == (ea >> 3)) ref_res_v = 0;
    end
    @(negedge clk);
    chk(ld_valid == exp_rd, "R4", "ld_valid", 64'(ld_valid), 64'(exp_rd));
    if (exp_rd)
      chk(ld_data == exp_ld, esz == 2 ? "R5" : (esz == 3 ? "R6" : "R4"), "ld_data",
          ld_data, exp_ld);
    chk(stx_valid == exp_stx, exp_stx ? "R9" : "R7", "stx_valid", 64'(stx_valid), 64'(exp_stx));
    if (exp_stx)
      chk(stx_status == (stx_ok ? 64'd0 : 64'd1), stx_ok ? "R9" : "R10", "stx_status",
          stx_status, stx_ok ? 64'd0 : 64'd1);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      tb_mem[i]  = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_1111_1111_1111);
      ref_mem[i] = tb_mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ld_valid && !stx_valid && !mem_wr_en && !mem_rd_en && !align_err, "R4",
        "reset quiet", {ld_valid, stx_valid, mem_wr_en, mem_rd_en, align_err}, 0);
    rst_n = 1;
    // R3 sized stores, R4/R5/R6 sized loads
    do_req(1, 3, 64'h40, 12'h0, 64'hF0E1_D2C3_B4A5_9687);
    do_req(0, 0, 64'h40, 12'h5, '0);
    do_req(0, 0, 64'h47, 12'h0, '0);
    do_req(0, 1, 64'h46, 12'h0, '0);
    do_req(0, 2, 64'h44, 12'h0, '0);
    do_req(0, 2, 64'h40, 12'h0, '0);
    do_req(1, 2, 64'h48, 12'h0, 64'hAAAA_AAAA_1234_5678);
    do_req(1, 1, 64'h48, 12'h2, 64'hFFFF_FFFF_FFFF_BEEF);
    do_req(1, 0, 64'h4F, 12'h0, 64'hFFFF_FFFF_FFFF_FF5A);
    do_req(0, 2, 64'h48, 12'h0, '0);
    do_req(0, 3, 64'h48, 12'h0, '0);
    // R1 negative and positive offsets
    do_req(0, 3, 64'h60, 12'hFF0, '0);
    do_req(0, 0, 64'h30, 12'h13, '0);
    // R7 misaligned accesses, then confirm memory untouched
    do_req(0, 1, 64'h41, 12'h0, '0);
    do_req(1, 2, 64'h4A, 12'h0, 64'h1);
    do_req(1, 3, 64'h48, 12'h4, 64'h2);
    do_req(0, 3, 64'h48, 12'h0, '0);
    // R10 stx without reservation
    do_req(3, 3, 64'h80, 12'h0, 64'hDEAD);
    do_req(0, 3, 64'h80, 12'h0, '0);
    // R8/R9 ldx then stx success; offset ignored (R2)
    do_req(2, 0, 64'h80, 12'h10, '0);
    do_req(3, 1, 64'h80, 12'h8, 64'h1111_2222_3333_4444);
    do_req(0, 3, 64'h80, 12'h0, '0);
    do_req(3, 3, 64'h80, 12'h0, 64'h5);            // R11 cleared, fails
    // R11 plain store to reserved dword clears
    do_req(2, 3, 64'h88, 12'h0, '0);
    do_req(1, 0, 64'h8B, 12'h0, 64'h77);
    do_req(3, 3, 64'h88, 12'h0, 64'h6);
    // R11 other-dword store and a load leave reservation
    do_req(2, 3, 64'h90, 12'h0, '0);
    do_req(1, 3, 64'h98, 12'h0, 64'h9);
    do_req(0, 3, 64'h90, 12'h0, '0);
    do_req(3, 3, 64'h90, 12'h0, 64'hCAFE_F00D);
    // R10 mismatch address, then R8 replacement
    do_req(2, 3, 64'hA0, 12'h0, '0);
    do_req(3, 3, 64'hA8, 12'h0, 64'h3);
    do_req(2, 3, 64'hA0, 12'h0, '0);
    do_req(2, 3, 64'hB0, 12'h0, '0);
    do_req(3, 3, 64'hA0, 12'h0, 64'h4);
    do_req(3, 3, 64'hB0, 12'h0, 64'h4);
    // R7 misaligned exclusives leave reservation
    do_req(2, 3, 64'hC0, 12'h0, '0);
    do_req(3, 3, 64'hC4, 12'h0, 64'h8);
    do_req(2, 3, 64'hD2, 12'h0, '0);
    do_req(3, 3, 64'hC0, 12'h0, 64'h8);
    do_req(0, 3, 64'hC0, 12'h0, '0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule